// File: doc/BRIEF.md
# Floating-Point Coprocessor Command Dispatch Front End

This block sits between a host that talks over a simple 32-bit register-mapped bus and a floating-point execution core. The host first writes a 32-bit operand and then a command word. The block reads the opcode field of the command word as the processor's own opcode extension value, with no remapping, and turns it into a compact internal operation code. It then passes the operation and its operand to the execution core over a start/accept handshake, and takes the result back over a done/ready handshake. Results can then be read from a result register. A status register shows the progress of the work.

Two operations can be outstanding at once: one in the core and one in a one-deep pending slot. The pending slot is emptied only when the core actually takes its instruction. A command that arrives while the current operation is retiring is therefore never dropped. A sequencer with three states drives the core side. SEQ_IDLE means nothing is executing. It moves to SEQ_ISSUE as soon as the pending slot holds an instruction. SEQ_ISSUE holds the start request and moves to SEQ_EXEC on the cycle the core accepts. SEQ_EXEC waits for the core's done. It returns to SEQ_IDLE on the cycle the result is loaded, which happens only while the result register is empty.

Bus offsets (byte addresses): 0x0 command, 0x4 operand, 0x8 result, 0xC status.

Top module: `fpu_cmd_frontend`

## Requirements
- R1: Command bits [6:0] hold the opcode. Opcodes 0x00, 0x04, 0x0E, 0x20, 0x22, 0x23 and 0x28 are issued on ex_op as 0 (move), 1 (sqrt), 2 (sine), 3 (divide), 4 (add), 5 (multiply) and 6 (subtract). The upper command bits are ignored.
- R2: A write to offset 0x4 latches all 32 bits in one cycle, and the operand register reads back the full word. An accepted command carries the operand latched at the moment of its write, and ex_operand presents that value.
- R3: A supported command accepted while another operation executes is held in the pending slot. Status then reads busy (bit 0) = 1 and pending-full (bit 1) = 1.
- R4: While the pending slot is full, a write to the command register sees bus_wr_ready low and is dropped. That command is never issued. Operand writes are always accepted.
- R5: The pending flag clears only on the cycle ex_start and ex_accept are both high. The retirement of the prior operation leaves the flag set.
- R6: An opcode outside the R1 set is accepted on the bus, is never issued, and sets unimplemented (status bit 3). A status read clears that bit.
- R7: Results come back in issue order through offset 0x8. Status bit 2 (result-valid) is set when a result is loaded, and a result read clears it. ex_res_ready stays low while result-valid is set.
- R8: While ex_start is high and ex_accept is low, ex_start, ex_op and ex_operand hold their values.
- R9: A synchronous active-high reset empties the pending slot and returns the sequencer to SEQ_IDLE. It clears result-valid and unimplemented, so status reads 0 and a command write sees ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_valid | input | 1 | Host write request |
| bus_wr_ready | output | 1 | Write accepted this cycle |
| bus_wr_addr | input | ADDR_W | Write byte offset |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_valid | input | 1 | Host read request (side effects at the clock edge) |
| bus_rd_addr | input | ADDR_W | Read byte offset |
| bus_rd_data | output | DATA_W | Read data, same cycle |
| ex_start | output | 1 | Instruction offered to the core |
| ex_op | output | 3 | Internal operation code |
| ex_operand | output | DATA_W | Operand for the offered instruction |
| ex_accept | input | 1 | Core takes the offered instruction |
| ex_done | input | 1 | Core has a result |
| ex_result | input | DATA_W | Result value |
| ex_res_ready | output | 1 | Front end can load the result |

## Verification
The bench stretches one operation over a long latency and queues a second command behind it. It holds the core's accept low so that the first operation retires while the second is still pending. A design that clears the flag on retirement would lose the second instruction or report an empty slot. A third command is sent against the full slot. A design that does not refuse it would overwrite the queued instruction, and the refused command would show up as an extra start. Late operand writes while an instruction waits show whether the operand was captured at command time; a design that reads the live register would issue the wrong operand. Opcodes just outside the supported set, and upper command bits that are not zero, catch decoders that look at too few or too many bits.

// File: rtl/fpu_cmd_pkg.sv
package fpu_cmd_pkg;

    localparam int OPC_W = 7;
    localparam int N_OPS = 7;

    typedef enum logic [2:0] {
        OP_MOVE = 3'd0,
        OP_SQRT = 3'd1,
        OP_SIN  = 3'd2,
        OP_DIV  = 3'd3,
        OP_ADD  = 3'd4,
        OP_MUL  = 3'd5,
        OP_SUB  = 3'd6
    } fp_op_e;

    localparam int OP_W = $bits(fp_op_e);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_EXEC  = 2'd2
    } seq_state_e;

    localparam int ST_BUSY   = 0;
    localparam int ST_PEND   = 1;
    localparam int ST_RESV   = 2;
    localparam int ST_UNIMPL = 3;

endpackage

// File: rtl/fpu_op_decode.sv
module fpu_op_decode
    import fpu_cmd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output fp_op_e           op,
    output logic             supported
);

    // Native extension opcodes, indexed by internal operation code.
    localparam logic [OPC_W-1:0] NATIVE [N_OPS] = '{
        7'h00, 7'h04, 7'h0E, 7'h20, 7'h22, 7'h23, 7'h28
    };

    always_comb begin
        op        = OP_MOVE;
        supported = 1'b0;
        for (int i = 0; i < N_OPS; i++) begin
            if (opcode == NATIVE[i]) begin
                op        = fp_op_e'(i[OP_W-1:0]);
                supported = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpu_bus_regs.sv
module fpu_bus_regs
    import fpu_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pend_full,
    input  logic              busy,
    input  logic              unimpl_set,
    input  logic              res_load,
    input  logic [DATA_W-1:0] res_data,
    output logic              cmd_fire,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [DATA_W-1:0] operand_q,
    output logic              res_full
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OPND = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12);

    logic              opnd_fire;
    logic              rd_res;
    logic              rd_stat;
    logic [DATA_W-1:0] res_q;
    logic              res_valid_q;
    logic              unimpl_q;
    logic [DATA_W-1:0] status_w;

    always_comb begin
        wr_ready   = (wr_addr == A_CMD) ? !pend_full : 1'b1;
        cmd_fire   = wr_valid && (wr_addr == A_CMD) && !pend_full;
        opnd_fire  = wr_valid && (wr_addr == A_OPND);
        cmd_opcode = wr_data[OPC_W-1:0];
        rd_res     = rd_valid && (rd_addr == A_RES);
        rd_stat    = rd_valid && (rd_addr == A_STAT);
        res_full   = res_valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            operand_q <= '0;
        end else if (opnd_fire) begin
            operand_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q       <= '0;
            res_valid_q <= 1'b0;
        end else if (res_load) begin
            res_q       <= res_data;
            res_valid_q <= 1'b1;
        end else if (rd_res) begin
            res_valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unimpl_q <= 1'b0;
        end else if (unimpl_set) begin
            unimpl_q <= 1'b1;
        end else if (rd_stat) begin
            unimpl_q <= 1'b0;
        end
    end

    always_comb begin
        status_w             = '0;
        status_w[ST_BUSY]    = busy;
        status_w[ST_PEND]    = pend_full;
        status_w[ST_RESV]    = res_valid_q;
        status_w[ST_UNIMPL]  = unimpl_q;
    end

    always_comb begin
        unique case (rd_addr)
            A_OPND:  rd_data = operand_q;
            A_RES:   rd_data = res_q;
            A_STAT:  rd_data = status_w;
            default: rd_data = '0;
        endcase
    end

    assert_operand_whole_R2: assert property (@(posedge clk) disable iff (rst)
        opnd_fire |=> (operand_q == $past(wr_data)))
        else $error("operand not latched as one word");

    assert_result_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_res && !res_load) |=> !res_valid_q)
        else $error("result-valid survived a result read");

    assert_unimpl_sets_R6: assert property (@(posedge clk) disable iff (rst)
        unimpl_set |=> unimpl_q)
        else $error("unimplemented flag not raised");

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid_q && !unimpl_q))
        else $error("flags not cleared by reset");

endmodule

// File: rtl/fpu_issue_seq.sv
module fpu_issue_seq
    import fpu_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  fp_op_e            push_op,
    input  logic [DATA_W-1:0] push_opd,
    output logic              pend_full,
    output logic              busy,
    output logic              ex_start,
    output fp_op_e            ex_op,
    output logic [DATA_W-1:0] ex_operand,
    input  logic              ex_accept,
    input  logic              ex_done,
    output logic              ex_res_ready,
    input  logic              res_full,
    output logic              res_load
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              pend_q;
    fp_op_e            pend_op_q;
    logic [DATA_W-1:0] pend_opd_q;
    logic              take;

    assign take = (state_q == SEQ_ISSUE) && ex_accept;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (pend_q)                state_d = SEQ_ISSUE;
            SEQ_ISSUE: if (ex_accept)             state_d = SEQ_EXEC;
            SEQ_EXEC:  if (ex_done && !res_full)  state_d = SEQ_IDLE;
            default:                              state_d = SEQ_IDLE;
        endcase
    end

    // Pending slot: flag drops only when the core takes the instruction
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_op_q  <= OP_MOVE;
            pend_opd_q <= '0;
        end else if (take) begin
            pend_q <= 1'b0;
        end else if (push) begin
            pend_q     <= 1'b1;
            pend_op_q  <= push_op;
            pend_opd_q <= push_opd;
        end
    end

    // Outputs
    always_comb begin
        ex_start     = (state_q == SEQ_ISSUE);
        ex_res_ready = (state_q == SEQ_EXEC) && !res_full;
        res_load     = (state_q == SEQ_EXEC) && !res_full && ex_done;
        busy         = (state_q != SEQ_IDLE);
        pend_full    = pend_q;
        ex_op        = pend_op_q;
        ex_operand   = pend_opd_q;
    end

    assert_pend_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_full && !(ex_start && ex_accept)) |=> pend_full)
        else $error("pending flag dropped without a take");

    assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> !pend_full)
        else $error("push into a full pending slot");

    assert_start_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ex_start && !ex_accept) |=> (ex_start && $stable(ex_op) && $stable(ex_operand)))
        else $error("offered instruction changed before accept");

    assert_result_stall_R7: assert property (@(posedge clk) disable iff (rst)
        res_full |-> !ex_res_ready)
        else $error("result ready while result register full");

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pend_full && !busy && !ex_start))
        else $error("sequencer not idle after reset");

endmodule

// File: rtl/fpu_cmd_frontend.sv
module fpu_cmd_frontend
    import fpu_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_valid,
    output logic              bus_wr_ready,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              bus_rd_valid,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [DATA_W-1:0] bus_rd_data,
    output logic              ex_start,
    output logic [OP_W-1:0]   ex_op,
    output logic [DATA_W-1:0] ex_operand,
    input  logic              ex_accept,
    input  logic              ex_done,
    input  logic [DATA_W-1:0] ex_result,
    output logic              ex_res_ready
);

    logic              cmd_fire;
    logic [OPC_W-1:0]  cmd_opcode;
    logic [DATA_W-1:0] operand_q;
    logic              res_full;
    logic              res_load;
    logic              pend_full;
    logic              busy;
    fp_op_e            dec_op;
    logic              dec_ok;
    fp_op_e            seq_op;
    logic              push;
    logic              unimpl_set;

    assign push       = cmd_fire && dec_ok;
    assign unimpl_set = cmd_fire && !dec_ok;
    assign ex_op      = seq_op;

    fpu_bus_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (bus_wr_valid),
        .wr_addr    (bus_wr_addr),
        .wr_data    (bus_wr_data),
        .wr_ready   (bus_wr_ready),
        .rd_valid   (bus_rd_valid),
        .rd_addr    (bus_rd_addr),
        .rd_data    (bus_rd_data),
        .pend_full  (pend_full),
        .busy       (busy),
        .unimpl_set (unimpl_set),
        .res_load   (res_load),
        .res_data   (ex_result),
        .cmd_fire   (cmd_fire),
        .cmd_opcode (cmd_opcode),
        .operand_q  (operand_q),
        .res_full   (res_full)
    );

    fpu_op_decode u_dec (
        .opcode    (cmd_opcode),
        .op        (dec_op),
        .supported (dec_ok)
    );

    fpu_issue_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .push         (push),
        .push_op      (dec_op),
        .push_opd     (operand_q),
        .pend_full    (pend_full),
        .busy         (busy),
        .ex_start     (ex_start),
        .ex_op        (seq_op),
        .ex_operand   (ex_operand),
        .ex_accept    (ex_accept),
        .ex_done      (ex_done),
        .ex_res_ready (ex_res_ready),
        .res_full     (res_full),
        .res_load     (res_load)
    );

    assert_unsupported_not_issued_R6: assert property (@(posedge clk) disable iff (rst)
        ex_start |-> (ex_op < OP_W'(N_OPS)))
        else $error("out-of-range operation issued");

endmodule

// File: tb/tb_fpu_cmd_frontend.sv
module tb_fpu_cmd_frontend;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [AW-1:0] A_CMD  = 4'h0;
    localparam logic [AW-1:0] A_OPND = 4'h4;
    localparam logic [AW-1:0] A_RES  = 4'h8;
    localparam logic [AW-1:0] A_STAT = 4'hC;
    localparam int NV = 9;

    // {opcode[6:0], operand[31:0], expected op[2:0], supported}
    localparam logic [42:0] VEC [NV] = '{
        {7'h00, 32'h3F80_0000, 3'd0, 1'b1},
        {7'h04, 32'h4000_0000, 3'd1, 1'b1},
        {7'h0E, 32'h3F80_0001, 3'd2, 1'b1},
        {7'h20, 32'h4049_0FDB, 3'd3, 1'b1},
        {7'h22, 32'hC0A0_0000, 3'd4, 1'b1},
        {7'h23, 32'h1234_5678, 3'd5, 1'b1},
        {7'h28, 32'hFFFF_FFFF, 3'd6, 1'b1},
        {7'h01, 32'h0000_0001, 3'd0, 1'b0},
        {7'h7F, 32'h8000_0000, 3'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_valid = 1'b0;
    logic          bus_wr_ready;
    logic [AW-1:0] bus_wr_addr = '0;
    logic [DW-1:0] bus_wr_data = '0;
    logic          bus_rd_valid = 1'b0;
    logic [AW-1:0] bus_rd_addr = '0;
    logic [DW-1:0] bus_rd_data;
    logic          ex_start;
    logic [2:0]    ex_op;
    logic [DW-1:0] ex_operand;
    logic          ex_accept;
    logic          ex_done = 1'b0;
    logic [DW-1:0] ex_result = '0;
    logic          ex_res_ready;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // execution core stub
    bit          accept_en = 1'b1;
    int          lat = 1;
    bit          job = 1'b0;
    int          cnt = 0;
    logic [2:0]  j_op = '0;
    logic [DW-1:0] j_opd = '0;
    int          starts = 0;
    logic [2:0]  last_op = '0;
    logic [DW-1:0] last_opd = '0;

    always #10 clk = ~clk;

    assign ex_accept = accept_en;

    fpu_cmd_frontend #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .bus_wr_valid (bus_wr_valid),
        .bus_wr_ready (bus_wr_ready),
        .bus_wr_addr  (bus_wr_addr),
        .bus_wr_data  (bus_wr_data),
        .bus_rd_valid (bus_rd_valid),
        .bus_rd_addr  (bus_rd_addr),
        .bus_rd_data  (bus_rd_data),
        .ex_start     (ex_start),
        .ex_op        (ex_op),
        .ex_operand   (ex_operand),
        .ex_accept    (ex_accept),
        .ex_done      (ex_done),
        .ex_result    (ex_result),
        .ex_res_ready (ex_res_ready)
    );

    function automatic logic [DW-1:0] stub_res(input logic [2:0] op, input logic [DW-1:0] opd);
        return (opd ^ 32'hA5A5_0000) + {29'd0, op};
    endfunction

    always @(posedge clk) begin
        if (ex_start && ex_accept) begin
            job      <= 1'b1;
            cnt      <= lat;
            j_op     <= ex_op;
            j_opd    <= ex_operand;
            last_op  <= ex_op;
            last_opd <= ex_operand;
            starts   <= starts + 1;
        end else if (job && !ex_done) begin
            if (cnt == 0) begin
                ex_done   <= 1'b1;
                ex_result <= stub_res(j_op, j_opd);
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (ex_done && ex_res_ready) begin
            ex_done <= 1'b0;
            job     <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic rdy);
        @(negedge clk);
        bus_wr_valid = 1'b1;
        bus_wr_addr  = a;
        bus_wr_data  = d;
        #1 rdy = bus_wr_ready;
        @(posedge clk);
        #1 bus_wr_valid = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd_valid = 1'b1;
        bus_rd_addr  = a;
        #1 d = bus_rd_data;
        @(posedge clk);
        #1 bus_rd_valid = 1'b0;
    endtask

    task automatic wait_res(output logic [DW-1:0] st);
        st = '0;
        for (int k = 0; k < 400; k++) begin
            bus_rd(A_STAT, st);
            if (st[2]) break;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic          rdy;
        logic [DW-1:0] d;
        logic [DW-1:0] st;
        int            s0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state
        bus_rd(A_STAT, d);
        chk("R9 status after reset", d, 32'h0);
        chk("R9 no start after reset", {31'd0, ex_start}, 32'd0);

        // Vector walk: R1, R2, R6, R7
        for (int i = 0; i < NV; i++) begin
            logic [6:0]  opc;
            logic [DW-1:0] opd;
            logic [2:0]  eop;
            logic        sup;
            opc = VEC[i][42:36];
            opd = VEC[i][35:4];
            eop = VEC[i][3:1];
            sup = VEC[i][0];
            lat = (i % 3) + 1;
            bus_wr(A_OPND, opd, rdy);
            bus_rd(A_OPND, d);
            chk("R2 operand readback", d, opd);
            s0 = starts;
            bus_wr(A_CMD, {25'h15A_5A5, opc}, rdy);
            chk("R9 command ready when slot empty", {31'd0, rdy}, 32'd1);
            if (sup) begin
                wait_res(st);
                chk("R7 result-valid set", {31'd0, st[2]}, 32'd1);
                chk("R1 issued op", {29'd0, last_op}, {29'd0, eop});
                chk("R2 issued operand", last_opd, opd);
                bus_rd(A_RES, d);
                chk("R7 result value", d, stub_res(eop, opd));
                bus_rd(A_STAT, d);
                chk("R7 result-valid cleared by read", {31'd0, d[2]}, 32'd0);
            end else begin
                repeat (4) @(posedge clk);
                bus_rd(A_STAT, d);
                chk("R6 unimplemented bit set", {31'd0, d[3]}, 32'd1);
                chk("R6 unsupported not issued", starts - s0, 0);
                bus_rd(A_STAT, d);
                chk("R6 unimplemented cleared by status read", {31'd0, d[3]}, 32'd0);
            end
        end

        // Directed: two in flight, refusal, pending kept across retirement
        lat = 30;
        accept_en = 1'b1;
        s0 = starts;
        bus_wr(A_OPND, 32'h1111_2222, rdy);
        bus_wr(A_CMD, 32'h0000_0022, rdy);
        repeat (4) @(posedge clk);
        bus_wr(A_OPND, 32'h3333_4444, rdy);
        bus_wr(A_CMD, 32'h0000_0023, rdy);
        chk("R3 second command accepted", {31'd0, rdy}, 32'd1);
        bus_rd(A_STAT, d);
        chk("R3 busy and pending-full", {30'd0, d[1:0]}, 32'd3);
        bus_wr(A_CMD, 32'h0000_0028, rdy);
        chk("R4 command refused when full", {31'd0, rdy}, 32'd0);
        bus_wr(A_OPND, 32'h5555_6666, rdy);
        chk("R4 operand write accepted when full", {31'd0, rdy}, 32'd1);
        bus_rd(A_OPND, d);
        chk("R4 operand register updated", d, 32'h5555_6666);
        accept_en = 1'b0;
        wait_res(st);
        chk("R5 pending kept after retirement", {31'd0, st[1]}, 32'd1);
        bus_rd(A_RES, d);
        chk("R7 first result in order", d, stub_res(3'd4, 32'h1111_2222));
        repeat (5) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 start held without accept", {31'd0, ex_start}, 32'd1);
        chk("R8 held op is multiply", {29'd0, ex_op}, 32'd5);
        chk("R2 held operand captured at command", ex_operand, 32'h3333_4444);
        bus_rd(A_STAT, d);
        chk("R5 pending still set before accept", {31'd0, d[1]}, 32'd1);
        accept_en = 1'b1;
        lat = 2;
        wait_res(st);
        chk("R5 pending cleared after accept", {31'd0, st[1]}, 32'd0);
        bus_rd(A_RES, d);
        chk("R7 second result in order", d, stub_res(3'd5, 32'h3333_4444));
        repeat (6) @(posedge clk);
        chk("R4 refused command never issued", starts - s0, 2);

        // R9: reset mid-operation
        bus_wr(A_OPND, 32'h0BAD_F00D, rdy);
        bus_wr(A_CMD, 32'h0000_0004, rdy);
        bus_wr(A_CMD, 32'h0000_0077, rdy);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        bus_rd(A_STAT, d);
        chk("R9 status cleared by reset", d, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule